// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block watches for a sign of life from software. It keeps a 64-bit compare value and checks it against a free-running 64-bit system count that comes from outside the block. Software holds the timer off by refreshing it. A refresh moves the deadline to the current count plus a programmable offset. If the count reaches the deadline, a first-stage warning goes high and the deadline moves forward by one more offset. If the count reaches that second deadline with the warning still pending, a second-stage output goes high to request a reset. From a refresh to the reset request, the total time is therefore twice the offset.

Two separate bus ports give access to two register frames. The refresh frame does only one thing: any write to its first word is a refresh. Because no register in that frame stores data, its port has no write-data lines. The control frame holds a control/status word, the offset and the compare value, and it also accepts refreshes. Both frames carry two read-only identification words. Reads are combinational: the read data is valid in the same cycle as select with write low. Writes take effect on the rising clock edge.

Top module: `wdog_twostage`

## Requirements
- R1: After a synchronous active-low reset, the enable, both stage flags, the offset and the compare value are zero, and both stage outputs are low.
- R2: The control-frame word at 0x000 reads back with the enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2. All other bits read 0. Writes change only the enable (bit 0). The two flag bits are read-only.
- R3: A refresh loads the compare value with the system count sampled at that edge plus the offset, and clears both stage flags.
- R4: While enabled and not refreshed, a count greater than or equal to the compare value with the first-stage flag clear sets that flag on the next edge. On the same edge the compare value reloads to count plus offset.
- R5: While enabled and not refreshed, a count greater than or equal to the compare value with the first-stage flag set raises the second-stage flag. That flag stays high until a refresh or a disable.
- R6: A refresh is caused by three kinds of write: a write of any value to refresh-frame word 0x000, a write to control word 0x000 and a write to the offset word.
- R7: While the enable is 0, both stage flags are 0, no compare takes place and the compare value is not reloaded by the timer. A write of 0 to the control word disables the timer.
- R8: In both frames, word 0xFCC reads the interface ID (default 0x0A5D0001) and word 0xFD0 reads the block ID (default 0x00003E71). Writes to these words are ignored. Unmapped words read 0.
- R9: An offset of zero makes the first stage fire on the edge after the refresh and the second stage fire on the edge after that, as long as the count is held.
- R10: The compare value is readable and writable as a low word at 0x010 and a high word at 0x014. A direct write does not refresh the timer, and the stages then follow the written value.
- R11: The offset is a 32-bit register at control word 0x008 and reads back as written.
- R12: The stage outputs are registered levels equal to the first-stage and second-stage flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| rf_sel | input | 1 | Refresh-frame access select |
| rf_wr | input | 1 | Refresh-frame write (1) or read (0) |
| rf_addr | input | 12 | Refresh-frame byte offset |
| rf_rdata | output | 32 | Refresh-frame read data |
| cf_sel | input | 1 | Control-frame access select |
| cf_wr | input | 1 | Control-frame write (1) or read (0) |
| cf_addr | input | 12 | Control-frame byte offset |
| cf_wdata | input | 32 | Control-frame write data |
| cf_rdata | output | 32 | Control-frame read data |
| stage1_o | output | 1 | First-stage warning level |
| stage2_o | output | 1 | Second-stage reset-request level |

## Verification
The hardest state to reach is the second stage: the count must cross two deadlines in turn, and the second deadline depends on where the count stood when the first stage fired. The bench drives the system count directly instead of letting it run. It parks the count just below a deadline, then steps it exactly onto the deadline, so every reload value is known before it is read back. With an offset above zero, extra edges at a held count change nothing. A zero offset is the exception: there the bench samples the outputs edge by edge to see both stages fire on consecutive cycles.

// File: rtl/wdt_pkg.sv
// Package: shared register indices, frame offsets and the read multiplexer
// of the two-stage watchdog. Assumes 32-bit bus words and a 64-bit count.
package wdt_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 64;

    // Byte offsets within a frame; the stage flag positions are decoded by software.
    localparam int OFS_CTRL    = 'h000;
    localparam int OFS_OFFSET  = 'h008;
    localparam int OFS_CMP_LO  = 'h010;
    localparam int OFS_CMP_HI  = 'h014;
    localparam int OFS_IFACEID = 'hFCC;
    localparam int OFS_BLOCKID = 'hFD0;
    localparam int OFS_KICK    = 'h000;

    localparam int BIT_EN  = 0;
    localparam int BIT_ST1 = 1;
    localparam int BIT_ST2 = 2;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_OFFSET,
        RG_CMP_LO,
        RG_CMP_HI,
        RG_IFACEID,
        RG_BLOCKID,
        RG_KICK
    } reg_e;

    // Purpose: map a decoded register to its read word.
    function automatic logic [WORD_W-1:0] read_word(
        input reg_e               sel,
        input logic               en,
        input logic               st1,
        input logic               st2,
        input logic [WORD_W-1:0]  offset,
        input logic [CNT_W-1:0]   cmp,
        input logic [WORD_W-1:0]  iface_id,
        input logic [WORD_W-1:0]  block_id
    );
        logic [WORD_W-1:0] w;
        w = '0;
        case (sel)
            RG_CTRL: begin
                w[BIT_EN]  = en;
                w[BIT_ST1] = st1;
                w[BIT_ST2] = st2;
            end
            RG_OFFSET:  w = offset;
            RG_CMP_LO:  w = cmp[WORD_W-1:0];
            RG_CMP_HI:  w = cmp[CNT_W-1:WORD_W];
            RG_IFACEID: w = iface_id;
            RG_BLOCKID: w = block_id;
            default:    w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wdt_frame_decode.sv
// Module: address decoder for one register frame. CTRL_FRAME selects the
// control-frame map or the refresh-frame map. Purely combinational; assumes
// the bus holds sel/wr/addr stable around the sampling edge.
module wdt_frame_decode
    import wdt_pkg::*;
#(
    parameter int AW         = 12,
    parameter bit CTRL_FRAME = 1'b1
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output reg_e          rd_reg,
    output reg_e          wr_reg
);

    reg_e hit;

    generate
        if (CTRL_FRAME) begin : g_ctrl
            // Purpose: decode the control-frame register map.
            always_comb begin
                hit = RG_NONE;
                if      (addr == AW'(OFS_CTRL))    hit = RG_CTRL;
                else if (addr == AW'(OFS_OFFSET))  hit = RG_OFFSET;
                else if (addr == AW'(OFS_CMP_LO))  hit = RG_CMP_LO;
                else if (addr == AW'(OFS_CMP_HI))  hit = RG_CMP_HI;
                else if (addr == AW'(OFS_IFACEID)) hit = RG_IFACEID;
                else if (addr == AW'(OFS_BLOCKID)) hit = RG_BLOCKID;
            end
        end else begin : g_kick
            // Purpose: decode the refresh-frame register map.
            always_comb begin
                hit = RG_NONE;
                if      (addr == AW'(OFS_KICK))    hit = RG_KICK;
                else if (addr == AW'(OFS_IFACEID)) hit = RG_IFACEID;
                else if (addr == AW'(OFS_BLOCKID)) hit = RG_BLOCKID;
            end
        end
    endgenerate

    // Purpose: qualify the hit by access direction.
    always_comb begin
        rd_reg = (sel && !wr) ? hit : RG_NONE;
        wr_reg = (sel &&  wr) ? hit : RG_NONE;
    end

endmodule

// File: rtl/wdt_timer_core.sv
// Module: watchdog state. Holds the enable, offset, compare value and the two
// stage flags, and runs the refresh, compare and reload logic against the
// external count. Assumes at most one write from the control frame per cycle;
// a refresh outranks a direct compare write and the timer's own reload.
module wdt_timer_core #(
    parameter int CW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          kick,
    input  logic          ctrl_wr,
    input  logic          off_wr,
    input  logic          cmp_lo_wr,
    input  logic          cmp_hi_wr,
    input  logic [DW-1:0] wdata,
    output logic          en,
    output logic          st1,
    output logic          st2,
    output logic [DW-1:0] offset,
    output logic [CW-1:0] cmp
);

    logic          refresh;
    logic [DW-1:0] off_eff;
    logic [CW-1:0] deadline;
    logic          expired;

    // Purpose: gather refresh sources and the offset in force this cycle.
    always_comb begin
        refresh  = kick | ctrl_wr | off_wr;
        off_eff  = off_wr ? wdata : offset;
        deadline = cnt + {{(CW-DW){1'b0}}, off_eff};
        expired  = en && (cnt >= cmp);
    end

    // Purpose: enable and offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            offset <= '0;
        end else begin
            if (ctrl_wr) en <= wdata[0];
            if (off_wr)  offset <= wdata;
        end
    end

    // Purpose: stage flags and compare value, refresh first, then timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= 1'b0;
            st2 <= 1'b0;
            cmp <= '0;
        end else if (refresh) begin
            st1 <= 1'b0;
            st2 <= 1'b0;
            cmp <= deadline;
        end else begin
            if (cmp_lo_wr) cmp[DW-1:0]  <= wdata;
            if (cmp_hi_wr) cmp[CW-1:DW] <= wdata[CW-DW-1:0];
            if (!en) begin
                st1 <= 1'b0;
                st2 <= 1'b0;
            end else if (expired) begin
                if (!st1) begin
                    st1 <= 1'b1;
                    if (!cmp_lo_wr && !cmp_hi_wr) cmp <= deadline;
                end else begin
                    st2 <= 1'b1;
                end
            end
        end
    end

    AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!st1 && !st2)); // R3

    AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !off_wr) |=> (cmp == $past(cnt + {{(CW-DW){1'b0}}, offset}))); // R3

    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !refresh && !st1 && (cnt >= cmp)) |=> st1); // R4

    AST_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !refresh && st1 && (cnt >= cmp)) |=> st2); // R5

    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        st2 |-> st1); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!st1 && !st2)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !refresh && !cmp_lo_wr && !cmp_hi_wr) |=> $stable(cmp)); // R7

endmodule

// File: rtl/wdog_twostage.sv
// Module: top of the two-stage watchdog. Two bus ports, one per frame, feed
// the decoders; the core keeps state; reads are combinational. Assumes the
// system count is synchronous to clk.
module wdog_twostage
    import wdt_pkg::*;
#(
    parameter int          AW       = 12,
    parameter logic [31:0] IFACE_ID = 32'h0A5D_0001,
    parameter logic [31:0] BLOCK_ID = 32'h0000_3E71
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [63:0]   sys_cnt,
    input  logic          rf_sel,
    input  logic          rf_wr,
    input  logic [AW-1:0] rf_addr,
    output logic [31:0]   rf_rdata,
    input  logic          cf_sel,
    input  logic          cf_wr,
    input  logic [AW-1:0] cf_addr,
    input  logic [31:0]   cf_wdata,
    output logic [31:0]   cf_rdata,
    output logic          stage1_o,
    output logic          stage2_o
);

    reg_e          rf_rd, rf_wrr, cf_rd, cf_wrr;
    logic          en, st1, st2;
    logic [31:0]   offset;
    logic [63:0]   cmp;

    wdt_frame_decode #(.AW(AW), .CTRL_FRAME(1'b0)) u_kick_dec (
        .sel(rf_sel), .wr(rf_wr), .addr(rf_addr),
        .rd_reg(rf_rd), .wr_reg(rf_wrr)
    );

    wdt_frame_decode #(.AW(AW), .CTRL_FRAME(1'b1)) u_ctrl_dec (
        .sel(cf_sel), .wr(cf_wr), .addr(cf_addr),
        .rd_reg(cf_rd), .wr_reg(cf_wrr)
    );

    wdt_timer_core #(.CW(CNT_W), .DW(WORD_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (sys_cnt),
        .kick      (rf_wrr == RG_KICK),
        .ctrl_wr   (cf_wrr == RG_CTRL),
        .off_wr    (cf_wrr == RG_OFFSET),
        .cmp_lo_wr (cf_wrr == RG_CMP_LO),
        .cmp_hi_wr (cf_wrr == RG_CMP_HI),
        .wdata     (cf_wdata),
        .en        (en),
        .st1       (st1),
        .st2       (st2),
        .offset    (offset),
        .cmp       (cmp)
    );

    // Purpose: read data for both frames and the stage outputs.
    always_comb begin
        rf_rdata = read_word(rf_rd, en, st1, st2, offset, cmp, IFACE_ID, BLOCK_ID);
        cf_rdata = read_word(cf_rd, en, st1, st2, offset, cmp, IFACE_ID, BLOCK_ID);
        stage1_o = st1;
        stage2_o = st2;
    end

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_rd == RG_BLOCKID) |-> (cf_rdata == BLOCK_ID)); // R8

endmodule

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        rf_sel = 1'b0, rf_wr = 1'b0;
    logic [11:0] rf_addr = '0;
    logic [31:0] rf_rdata;
    logic        cf_sel = 1'b0, cf_wr = 1'b0;
    logic [11:0] cf_addr = '0;
    logic [31:0] cf_wdata = '0;
    logic [31:0] cf_rdata;
    logic        stage1_o, stage2_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    wdog_twostage uut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
        .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .cf_rdata(cf_rdata), .stage1_o(stage1_o), .stage2_o(stage2_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cf_sel = 1'b1; cf_wr = 1'b1; cf_addr = a; cf_wdata = d;
        @(negedge clk);
        cf_sel = 1'b0; cf_wr = 1'b0;
    endtask

    task automatic rf_write(input logic [11:0] a);
        @(negedge clk);
        rf_sel = 1'b1; rf_wr = 1'b1; rf_addr = a;
        @(negedge clk);
        rf_sel = 1'b0; rf_wr = 1'b0;
    endtask

    task automatic cf_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cf_sel = 1'b1; cf_wr = 1'b0; cf_addr = a;
        #2 d = cf_rdata;
        cf_sel = 1'b0;
    endtask

    task automatic rf_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rf_sel = 1'b1; rf_wr = 1'b0; rf_addr = a;
        #2 d = rf_rdata;
        rf_sel = 1'b0;
    endtask

    task automatic read_cmp(output logic [63:0] v);
        logic [31:0] lo, hi;
        cf_read(12'h010, lo);
        cf_read(12'h014, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic [63:0] c;
        chk("R1 stage1 low", stage1_o, 0);
        chk("R1 stage2 low", stage2_o, 0);
        cf_read(12'h000, d); chk("R1 ctrl zero", d, 0);
        cf_read(12'h008, d); chk("R1 offset zero", d, 0);
        read_cmp(c);         chk("R1 cmp zero", c, 0);
    endtask

    task automatic t_ids;
        logic [31:0] d;
        cf_read(12'hFCC, d); chk("R8 ctrl iface id", d, 32'h0A5D_0001);
        cf_read(12'hFD0, d); chk("R8 ctrl block id", d, 32'h0000_3E71);
        rf_read(12'hFCC, d); chk("R8 kick iface id", d, 32'h0A5D_0001);
        rf_read(12'hFD0, d); chk("R8 kick block id", d, 32'h0000_3E71);
        cf_write(12'hFCC, 32'h1234_5678);
        cf_read(12'hFCC, d); chk("R8 id write ignored", d, 32'h0A5D_0001);
        cf_read(12'h004, d); chk("R8 unmapped zero", d, 0);
        rf_read(12'h000, d); chk("R8 kick word reads zero", d, 0);
    endtask

    task automatic t_two_stages;
        logic [31:0] d;
        logic [63:0] c;
        sys_cnt = 64'd1000;
        cf_write(12'h000, 32'h1);
        cf_write(12'h008, 32'd100);
        cf_read(12'h008, d); chk("R11 offset readback", d, 100);
        read_cmp(c);         chk("R3 cmp after refresh", c, 1100);
        cf_read(12'h000, d); chk("R2 enabled flags clear", d, 32'h1);
        sys_cnt = 64'd1099; tick(3);
        chk("R4 no stage before deadline", stage1_o, 0);
        sys_cnt = 64'd1100; tick(3);
        chk("R4 stage1 at deadline", stage1_o, 1);
        chk("R12 stage2 still low", stage2_o, 0);
        read_cmp(c);         chk("R4 cmp reloaded", c, 1200);
        cf_read(12'h000, d); chk("R2 ctrl shows stage1", d, 32'h3);
        sys_cnt = 64'd1199; tick(3);
        chk("R5 no stage2 early", stage2_o, 0);
        sys_cnt = 64'd1250; tick(3);
        chk("R5 stage2 raised", stage2_o, 1);
        cf_read(12'h000, d); chk("R2 ctrl shows both", d, 32'h7);
        sys_cnt = 64'd1300;
        rf_write(12'h000);
        chk("R6 kick clears stage1", stage1_o, 0);
        chk("R6 kick clears stage2", stage2_o, 0);
        read_cmp(c);         chk("R6 kick reloads cmp", c, 1400);
    endtask

    task automatic t_ctrl_refresh;
        logic [31:0] d;
        logic [63:0] c;
        sys_cnt = 64'd1400; tick(2);
        chk("R6 stage1 before ctrl write", stage1_o, 1);
        sys_cnt = 64'd1450;
        cf_write(12'h000, 32'h7);
        chk("R6 ctrl write clears stage1", stage1_o, 0);
        cf_read(12'h000, d); chk("R2 flag bits read-only", d, 32'h1);
        read_cmp(c);         chk("R6 ctrl write reloads cmp", c, 1550);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        logic [63:0] c;
        sys_cnt = 64'd2000;
        cf_write(12'h000, 32'h0);
        sys_cnt = 64'd9000; tick(4);
        chk("R7 stage1 quiet", stage1_o, 0);
        chk("R7 stage2 quiet", stage2_o, 0);
        cf_read(12'h000, d); chk("R7 ctrl disabled", d, 0);
        read_cmp(c);         chk("R7 cmp not reloaded", c, 2100);
    endtask

    task automatic t_zero_offset;
        sys_cnt = 64'd500;
        cf_write(12'h000, 32'h1);
        cf_write(12'h008, 32'h0);
        chk("R9 refresh edge clear", stage1_o, 0);
        tick(1);
        chk("R9 stage1 next edge", stage1_o, 1);
        chk("R9 stage2 not yet", stage2_o, 0);
        tick(1);
        chk("R9 stage2 following edge", stage2_o, 1);
    endtask

    task automatic t_cmp_direct;
        logic [63:0] c;
        sys_cnt = 64'd5000;
        cf_write(12'h008, 32'd100);
        cf_write(12'h010, 32'd5050);
        chk("R10 direct write no refresh", stage1_o, 0);
        read_cmp(c); chk("R10 cmp low written", c, 5050);
        sys_cnt = 64'd5049; tick(2);
        chk("R10 before written deadline", stage1_o, 0);
        sys_cnt = 64'd5050; tick(2);
        chk("R10 fires at written deadline", stage1_o, 1);
        cf_write(12'h014, 32'h1);
        read_cmp(c); chk("R10 cmp high written", c, 64'h1_0000_0000 + 64'd5150);
        chk("R10 high write keeps stage1", stage1_o, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_ids();
        t_two_stages();
        t_ctrl_refresh();
        t_disable();
        t_zero_offset();
        t_cmp_direct();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule